// File: doc/BRIEF.md
# Exact-Ratio Modulo Phase Accumulator Synthesizer

This block makes a low-frequency periodic waveform from a fast reference clock, and the output frequency is an exact rational fraction of the clock. The phase register wraps at a modulus that is not a power of two. With a 10 MHz clock, a modulus of 500,000 and a step of 3, the output period is exactly 1/60 s. Because nothing is truncated, the output never drifts from the reference over any length of time.

Each enabled clock advances the phase by the step and wraps it at the modulus. The block gives out the phase word and a one-clock pulse on every wrap. It also gives three registered waveforms taken from the phase: a square wave, an unsigned triangle and a signed sine sample read from a quarter-wave table. A build parameter picks how the phase is made. One choice is a direct step-and-wrap accumulator. The other is a unit-step down-counter that reloads at the modulus, with the stepped phase rebuilt from the counter value. Both give the same behaviour at the ports.

Top module: `modulo_dds_top`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next state is phase 0 and `wrap_o` low. The waveform registers take the phase-0 values: `square_o`=1, `tri_o`=0, `sine_o`=0. Reset takes priority over `en_i`.
- R2: `phase_o` always lies in 0..MODULUS-1. Each rising edge with `en_i` high (and no reset) sets it to (phase + STEP) mod MODULUS. The defaults are MODULUS=500000 and STEP=3, which gives exactly 60 Hz from 10 MHz.
- R3: A rising edge with `en_i` low leaves `phase_o` unchanged, and `wrap_o` is low in the following cycle.
- R4: `wrap_o` is high for exactly the one cycle after an enabled update in which phase + STEP reached MODULUS or more. In that cycle `phase_o` < STEP. Over MODULUS·20/STEP... more plainly, over N enabled updates from phase 0 the pulse count is floor(N·STEP/MODULUS). This is 60 per 10,000,000 clocks at the defaults.
- R5: `square_o` is 1 when the phase one cycle earlier was below MODULUS/2, and 0 otherwise.
- R6: `tri_o` equals floor(f·8192/MODULUS) for the phase p of one cycle earlier. Here f = p for p < MODULUS/2 and f = MODULUS-1-p otherwise. The output rises over the first half and falls over the second.
- R7: `sine_o` (two's complement) equals round(2047·sin(2π·i/256)) within ±1 LSB for the phase p of one cycle earlier. The table index is i = floor(p·256/MODULUS).
- R8: The down-counter build (ARCH = ARCH_COUNTER) produces, cycle for cycle, the same `phase_o`, `wrap_o` and waveforms as the accumulator build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; low freezes the phase |
| phase_o | output | PHASE_W | Current phase, 0..MODULUS-1 |
| wrap_o | output | 1 | One-cycle pulse after each wrap |
| square_o | output | 1 | Square wave, high for the first half-cycle |
| tri_o | output | 12 | Unsigned triangle |
| sine_o | output | 12 | Signed sine sample |

## Verification
The bench drives a small modulus and runs the accumulator build and the down-counter build side by side. The bench targets the wrap boundary. A sum that lands exactly on the modulus must wrap to zero. A design using `>` instead of `>=` would show the modulus value on `phase_o`, and a binary-overflow design would miss pulses and fail the exact count of 60. Enable is toggled in irregular patterns and held low for long stretches, so a phase that creeps or a wrap that fires while stalled shows up at once. The half-period crossing checks for an off-by-one in the square threshold or in the triangle fold. The quadrant seams of the sine table catch a mirrored address that misses the table's peak entry. In the counter build, a wrong lane threshold would make the phase jump by a modulus at the lane seams.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic {
        ARCH_ACCUM   = 1'b0,
        ARCH_COUNTER = 1'b1
    } dds_arch_e;

    localparam int WAVE_W = 12;

    // Sine of (idx/qsize)*pi/2 scaled to 2047, via an odd Taylor series in Q30
    function automatic logic signed [WAVE_W-1:0] quarter_sine(input int idx, input int qsize);
        longint x;
        longint x2;
        longint term;
        longint acc;
        longint res;
        x    = (64'sd1686629713 * longint'(idx)) / longint'(qsize);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int n = 1; n <= 6; n++) begin
            term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        res = (acc * 2047 + (64'sd1 <<< 29)) >>> 30;
        if (res > 2047) res = 2047;
        if (res < 0) res = 0;
        return WAVE_W'(res);
    endfunction

endpackage

// File: rtl/dds_phase_core.sv
module dds_phase_core
    import dds_pkg::*;
#(
    parameter int        MODULUS = 500000,
    parameter int        STEP    = 3,
    parameter int        PHASE_W = 19,
    parameter dds_arch_e ARCH    = ARCH_ACCUM
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o
);

    generate
        if (ARCH == ARCH_ACCUM) begin : g_accum
            localparam logic [PHASE_W:0] STEP_X = (PHASE_W + 1)'(STEP);
            localparam logic [PHASE_W:0] MOD_X  = (PHASE_W + 1)'(MODULUS);

            typedef struct packed {
                logic [PHASE_W-1:0] phase;
                logic               wrap;
            } acc_state_t;

            acc_state_t       acc_d, acc_q;
            logic [PHASE_W:0] sum_w;

            assign sum_w = {1'b0, acc_q.phase} + STEP_X;

            always_comb begin
                acc_d      = acc_q;
                acc_d.wrap = 1'b0;
                if (en_i) begin
                    if (sum_w >= MOD_X) begin
                        acc_d.phase = PHASE_W'(sum_w - MOD_X);
                        acc_d.wrap  = 1'b1;
                    end else begin
                        acc_d.phase = PHASE_W'(sum_w);
                    end
                end
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) acc_q <= '0;
                else       acc_q <= acc_d;
            end

            assign phase_o = acc_q.phase;
            assign wrap_o  = acc_q.wrap;
        end else begin : g_counter
            localparam logic [PHASE_W-1:0] RELOAD = PHASE_W'(MODULUS - 1);

            typedef struct packed {
                logic [PHASE_W-1:0] remain;
                logic               wrap;
            } cnt_state_t;

            cnt_state_t   cnt_d, cnt_q;
            logic [63:0]  stepped_w;

            // Lane = how many whole moduli the stepped sequence has passed
            function automatic int lane_of(input logic [PHASE_W-1:0] r);
                int l;
                l = 0;
                for (int i = 1; i < STEP; i++) begin
                    if (longint'(r) <= longint'(MODULUS - 1)
                        - (longint'(i) * longint'(MODULUS) + longint'(STEP - 1)) / longint'(STEP))
                        l++;
                end
                return l;
            endfunction

            always_comb begin
                cnt_d      = cnt_q;
                cnt_d.wrap = 1'b0;
                if (en_i) begin
                    if (cnt_q.remain == '0) cnt_d.remain = RELOAD;
                    else                    cnt_d.remain = cnt_q.remain - 1'b1;
                    cnt_d.wrap = (cnt_q.remain == '0)
                               || (lane_of(cnt_d.remain) != lane_of(cnt_q.remain));
                end
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    cnt_q.remain <= RELOAD;
                    cnt_q.wrap   <= 1'b0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            always_comb begin
                stepped_w = 64'(longint'(STEP) * (longint'(MODULUS - 1) - longint'(cnt_q.remain))
                          - longint'(lane_of(cnt_q.remain)) * longint'(MODULUS));
            end

            assign phase_o = PHASE_W'(stepped_w);
            assign wrap_o  = cnt_q.wrap;
        end
    endgenerate

endmodule

// File: rtl/dds_ratio_scale.sv
module dds_ratio_scale #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 8,
    parameter int NUM   = 256,
    parameter int DEN   = 500000
) (
    input  logic [IN_W-1:0]  x_i,
    output logic [OUT_W-1:0] y_o
);

    // floor(x*NUM/DEN) through a rounded-up reciprocal; SH keeps it exact
    localparam int          DEN_W = $clog2(DEN) + 1;
    localparam int          SH    = IN_W + DEN_W;
    localparam logic [63:0] RECIP = ((64'(NUM) << SH) + 64'(DEN - 1)) / 64'(DEN);

    logic [63:0] prod_w;

    assign prod_w = 64'(x_i) * RECIP;
    assign y_o    = OUT_W'(prod_w >> SH);

endmodule

// File: rtl/dds_wave_shaper.sv
module dds_wave_shaper
    import dds_pkg::*;
#(
    parameter int MODULUS = 500000,
    parameter int PHASE_W = 19,
    parameter int QBITS   = 6
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [PHASE_W-1:0]       phase_i,
    output logic                     square_o,
    output logic [WAVE_W-1:0]        tri_o,
    output logic signed [WAVE_W-1:0] sine_o
);

    localparam int                 QSIZE  = 1 << QBITS;
    localparam int                 IDX_W  = QBITS + 2;
    localparam logic [PHASE_W-1:0] HALF   = PHASE_W'(MODULUS / 2);
    localparam logic [PHASE_W-1:0] LAST   = PHASE_W'(MODULUS - 1);
    localparam logic [QBITS:0]     QTOP   = (QBITS + 1)'(QSIZE);

    typedef struct packed {
        logic                     square;
        logic [WAVE_W-1:0]        tri_v;
        logic signed [WAVE_W-1:0] sine;
    } wave_t;

    wave_t                     w_d, w_q;
    logic [IDX_W-1:0]          idx_w;
    logic [PHASE_W-1:0]        fold_w;
    logic [WAVE_W-1:0]         ramp_w;
    logic [QBITS:0]            qaddr_w;
    logic signed [WAVE_W-1:0]  mag_w;
    logic signed [WAVE_W-1:0]  qtab [QSIZE + 1];

    genvar g;
    generate
        for (g = 0; g <= QSIZE; g++) begin : g_qtab
            assign qtab[g] = quarter_sine(g, QSIZE);
        end
    endgenerate

    assign fold_w = (phase_i < HALF) ? phase_i : (LAST - phase_i);

    dds_ratio_scale #(
        .IN_W (PHASE_W),
        .OUT_W(IDX_W),
        .NUM  (4 * QSIZE),
        .DEN  (MODULUS)
    ) u_idx (
        .x_i(phase_i),
        .y_o(idx_w)
    );

    dds_ratio_scale #(
        .IN_W (PHASE_W),
        .OUT_W(WAVE_W),
        .NUM  (1 << (WAVE_W + 1)),
        .DEN  (MODULUS)
    ) u_ramp (
        .x_i(fold_w),
        .y_o(ramp_w)
    );

    always_comb begin
        // odd quadrants read the table mirrored, upper half negates
        if (idx_w[IDX_W-2]) qaddr_w = QTOP - {1'b0, idx_w[QBITS-1:0]};
        else                qaddr_w = {1'b0, idx_w[QBITS-1:0]};
        mag_w = qtab[qaddr_w];

        w_d.square = (phase_i < HALF);
        w_d.tri_v  = ramp_w;
        w_d.sine   = idx_w[IDX_W-1] ? -mag_w : mag_w;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            w_q.square <= 1'b1;
            w_q.tri_v  <= '0;
            w_q.sine   <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign square_o = w_q.square;
    assign tri_o    = w_q.tri_v;
    assign sine_o   = w_q.sine;

endmodule

// File: rtl/modulo_dds_top.sv
module modulo_dds_top
    import dds_pkg::*;
#(
    parameter int        MODULUS    = 500000,
    parameter int        STEP       = 3,
    parameter int        PHASE_W    = $clog2(MODULUS),
    parameter int        SINE_QBITS = 6,
    parameter dds_arch_e ARCH       = ARCH_ACCUM
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o,
    output logic               square_o,
    output logic [11:0]        tri_o,
    output logic signed [11:0] sine_o
);

    logic [PHASE_W-1:0] phase_w;

    dds_phase_core #(
        .MODULUS(MODULUS),
        .STEP   (STEP),
        .PHASE_W(PHASE_W),
        .ARCH   (ARCH)
    ) u_core (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .phase_o(phase_w),
        .wrap_o (wrap_o)
    );

    dds_wave_shaper #(
        .MODULUS(MODULUS),
        .PHASE_W(PHASE_W),
        .QBITS  (SINE_QBITS)
    ) u_shape (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .phase_i (phase_w),
        .square_o(square_o),
        .tri_o   (tri_o),
        .sine_o  (sine_o)
    );

    assign phase_o = phase_w;

endmodule

// File: rtl/modulo_dds_chk.sv
module modulo_dds_chk #(
    parameter int MODULUS = 500000,
    parameter int STEP    = 3,
    parameter int PHASE_W = 19
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               en_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               wrap_o,
    input logic               square_o
);

    // R2
    phase_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(phase_o) < MODULUS);

    // R2
    phase_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (32'(phase_o) == (32'($past(phase_o)) + STEP) % MODULUS));

    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(phase_o) && !wrap_o));

    // R4
    wrap_low_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> (32'(phase_o) < STEP));

    // R4
    wrap_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);

    // R5
    square_lag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> (square_o == (32'($past(phase_o)) < MODULUS / 2)));

endmodule

bind modulo_dds_top modulo_dds_chk #(
    .MODULUS(MODULUS),
    .STEP   (STEP),
    .PHASE_W(PHASE_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .phase_o (phase_o),
    .wrap_o  (wrap_o),
    .square_o(square_o)
);

// File: tb/sim_modulo_dds_top.sv
module sim_modulo_dds_top;
    timeunit 1ns;
    timeprecision 1ps;

    import dds_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int M          = 2000;
    localparam int ST         = 3;
    localparam int PW         = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;

    logic [PW-1:0]       ph0, ph1;
    logic                wr0, wr1, sq0, sq1;
    logic [11:0]         tr0, tr1;
    logic signed [11:0]  sn0, sn1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_ph, m_wr, m_sq, m_tr, m_sn;
    int wraps0, wraps1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    modulo_dds_top #(.MODULUS(M), .STEP(ST), .PHASE_W(PW), .ARCH(ARCH_ACCUM)) u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .phase_o(ph0), .wrap_o(wr0),
        .square_o(sq0), .tri_o(tr0), .sine_o(sn0));

    modulo_dds_top #(.MODULUS(M), .STEP(ST), .PHASE_W(PW), .ARCH(ARCH_COUNTER)) u1 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .phase_o(ph1), .wrap_o(wr1),
        .square_o(sq1), .tri_o(tr1), .sine_o(sn1));

    function automatic int ref_sq(int p);
        return (p < M / 2) ? 1 : 0;
    endfunction

    function automatic int ref_tri(int p);
        int f;
        f = (p < M / 2) ? p : (M - 1 - p);
        return (f * 8192) / M;
    endfunction

    function automatic int ref_sine(int p);
        int  i;
        real v;
        i = (p * 256) / M;
        v = 2047.0 * $sin(2.0 * 3.14159265358979 * i / 256.0);
        return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic expect_eq(string tag, int act, int exp, int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        expect_eq("R2 phase u0", int'(ph0), m_ph, 0);
        expect_eq("R4 wrap u0", int'(wr0), m_wr, 0);
        expect_eq("R5 square u0", int'(sq0), m_sq, 0);
        expect_eq("R6 triangle u0", int'(tr0), m_tr, 0);
        expect_eq("R7 sine u0", int'(sn0), m_sn, 1);
        expect_eq("R8 phase u1", int'(ph1), m_ph, 0);
        expect_eq("R8 wrap u1", int'(wr1), m_wr, 0);
        expect_eq("R8 square u1", int'(sq1), m_sq, 0);
        expect_eq("R8 triangle u1", int'(tr1), m_tr, 0);
        expect_eq("R8 sine u1", int'(sn1), m_sn, 1);
    endtask

    // Drive one edge, advance the reference, then compare after the edge
    task automatic cycle(bit r, bit e);
        int n_ph, n_wr, src;
        rst = r;
        en  = e;
        if (r) begin
            n_ph = 0;
            n_wr = 0;
            src  = 0;
        end else begin
            src  = m_ph;
            n_wr = (e && (m_ph + ST >= M)) ? 1 : 0;
            n_ph = e ? (m_ph + ST) % M : m_ph;
        end
        @(negedge clk);
        m_ph = n_ph;
        m_wr = n_wr;
        m_sq = ref_sq(src);
        m_tr = ref_tri(src);
        m_sn = ref_sine(src);
        compare_all();
        if (wr0) wraps0++;
        if (wr1) wraps1++;
    endtask

    initial begin
        m_ph = 0; m_wr = 0; m_sq = 1; m_tr = 0; m_sn = 0;
        @(negedge clk);
        // R1: reset state, with en high as well
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        expect_eq("R1 reset phase", int'(ph0), 0, 0);
        expect_eq("R1 reset square", int'(sq0), 1, 0);
        expect_eq("R1 reset sine", int'(sn0), 0, 0);

        // R4: exact pulse count over 20*M enabled updates
        wraps0 = 0;
        wraps1 = 0;
        for (int i = 0; i < 20 * M; i++) cycle(1'b0, 1'b1);
        expect_eq("R4 wrap count u0", wraps0, 60, 0);
        expect_eq("R8 wrap count u1", wraps1, 60, 0);
        expect_eq("R2 phase back at zero", int'(ph0), 0, 0);

        // R3: irregular enable pattern
        for (int i = 0; i < 3000; i++) cycle(1'b0, (i % 7) < 3);

        // R3: long stall then resume
        for (int i = 0; i < 200; i++) cycle(1'b0, 1'b1);
        begin
            int held;
            held = int'(ph0);
            for (int i = 0; i < 60; i++) cycle(1'b0, 1'b0);
            expect_eq("R3 phase held", int'(ph0), held, 0);
        end

        // R1: mid-run reset, then random enables
        for (int i = 0; i < 777; i++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        expect_eq("R1 mid-run reset phase", int'(ph1), 0, 0);
        for (int i = 0; i < 4000; i++) cycle(1'b0, ($urandom % 4) != 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule